// File: doc/BRIEF.md
# Mode-Aware Parallel I/O Port Controller

This block is an eight-pin parallel I/O port run by four byte-wide registers on a simple register bus. A direction register and an output-data register set up general-purpose I/O. A pull-up register turns on weak pull-ups for input pins. A pin-state register reads the level on each pin. For every pin the block drives an output value, an output enable and a pull-up enable toward the pad.

The operating mode decides who owns each pin. In single-chip mode (7) the pins are general I/O. In the mixed mode (6) a direction bit of one hands the pin to the external address bus. In the expanded modes (4 and 5) every pin carries an address bit. Modes 0 to 3 leave every pin as an undriven input.

The block handles four conditions. Power-on reset and hardware standby clear the registers. Manual reset and software standby keep them. On entry to software standby, a standby output-enable input picks whether the address pins keep driving the last latched address or float.

Top module: `gpio_port_ctl`

## Requirements
- R1: After power-on reset the data and pull-up registers read 0x00, and pin_oe and pin_pu are 0x00 in mode 7.
- R2: A write with wr_en high takes effect at the next rising clock edge. While rd_en is high, rdata combinationally returns the register at addr: data register 0xFF6A, pull-up register 0xFF71, pin-state register 0xFF5A. While rd_en is low, rdata is 0x00. The direction register (0xFEBA) is write-only and reads a fixed filler value.
- R3: Writes to the pin-state address, or to any address outside the four, change no register.
- R4: In mode 7, pin_oe equals the direction register and pin_out equals the data register ANDed with the direction register.
- R5: In mode 6, pin_oe equals the direction register. On those pins pin_out carries addr_in as sampled at the previous rising edge.
- R6: In modes 4 and 5, pin_oe is 0xFF and pin_out is addr_in as sampled at the previous rising edge, whatever the direction register holds.
- R7: In modes 0 to 3, pin_oe and pin_pu are 0x00.
- R8: A pin-state read returns the data-register bit for pins that are general outputs (mode 7 and direction 1). Every other bit is the pin_in level present before the two most recent rising edges.
- R9: pin_pu for a bit is 1 only when its pull-up bit is 1, the pin is an input, the mode is 6 or 7, and hardware standby is low.
- R10: While hw_stby is high, pin_oe and pin_pu are 0x00, bus writes are dropped, and the direction, data and pull-up registers are cleared at each rising edge.
- R11: While man_rst is high, bus writes are dropped and all registers keep their values.
- R12: While sw_stby is high with stby_oe = 1, address pins keep driving the address latched before standby, even when addr_in changes.
- R13: While sw_stby is high with stby_oe = 0, address pins have pin_oe = 0 and pin_out = 0. General-output pins keep driving, and register contents survive standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby, active high |
| stby_oe | input | 1 | In software standby: 1 keeps address pins driven, 0 floats them |
| mode | input | 3 | Operating mode 0 to 7 |
| addr | input | 16 | Register bus address (low half) |
| wdata | input | 8 | Register bus write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Register bus read data |
| addr_in | input | 8 | Address bits from the bus controller |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
A bus write can land in the same cycle that hardware standby or manual reset is raised. The bench provokes this by holding wr_en together with hw_stby, and again together with man_rst. It then reads the register back: hardware standby must leave zero, and manual reset must leave the old value. A change in the address input can also meet the first cycle of software standby. The bench changes addr_in in the cycle that sw_stby rises and checks that the pins still show the address latched before standby.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    parameter int PORT_W = 8;
    parameter int BUS_AW = 16;
    parameter int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_EXP_A  = 3'd4;
    localparam logic [MODE_W-1:0] MODE_EXP_B  = 3'd5;
    localparam logic [MODE_W-1:0] MODE_MIXED  = 3'd6;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 3'd7;

    typedef enum logic [1:0] {
        ROLE_IN  = 2'd0,
        ROLE_GPO = 2'd1,
        ROLE_ADR = 2'd2
    } pin_role_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] dat;
        logic [PORT_W-1:0] pul;
    } port_regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];

    // R8
    sync_pipe_chk: assert property (@(posedge clk) disable iff (!por_n)
        stg_q[1] == $past(stg_q[0]));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter logic [BUS_AW-1:0] ADDR_DIR = 16'hFEBA,
    parameter logic [BUS_AW-1:0] ADDR_DAT = 16'hFF6A,
    parameter logic [BUS_AW-1:0] ADDR_PIN = 16'hFF5A,
    parameter logic [BUS_AW-1:0] ADDR_PUL = 16'hFF71,
    parameter logic [PORT_W-1:0] DIR_FILL = 8'h00
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_stby,
    input  logic              man_rst,
    input  logic [BUS_AW-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] gpo_mask,
    output port_regs_t        regs,
    output logic [PORT_W-1:0] rdata
);
    port_regs_t regs_d, regs_q;
    logic       wr_ok;
    logic [PORT_W-1:0] pin_view;

    assign wr_ok = wr_en && !hw_stby && !man_rst;

    always_comb begin
        regs_d = regs_q;
        if (hw_stby) begin
            regs_d = '0;
        end else if (wr_ok) begin
            if (addr == ADDR_DIR) regs_d.dir = wdata;
            if (addr == ADDR_DAT) regs_d.dat = wdata;
            if (addr == ADDR_PUL) regs_d.pul = wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pin_view = (gpo_mask & regs_q.dat) | (~gpo_mask & pin_sync);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if      (addr == ADDR_DIR) rdata = DIR_FILL;
            else if (addr == ADDR_DAT) rdata = regs_q.dat;
            else if (addr == ADDR_PIN) rdata = pin_view;
            else if (addr == ADDR_PUL) rdata = regs_q.pul;
        end
    end

    assign regs = regs_q;

    // R10
    hw_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (regs_q == '0));

    // R11
    man_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (man_rst && !hw_stby) |=> $stable(regs_q));

    // R3
    ro_ignore_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!hw_stby && addr != ADDR_DIR && addr != ADDR_DAT && addr != ADDR_PUL)
        |=> $stable(regs_q));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              stby_oe,
    input  logic [MODE_W-1:0] mode,
    input  port_regs_t        regs,
    input  logic [PORT_W-1:0] addr_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pu,
    output logic [PORT_W-1:0] gpo_mask
);
    logic [PORT_W-1:0] adr_d, adr_q;
    logic gpio_mode;

    always_comb begin
        adr_d = adr_q;
        if (hw_stby)      adr_d = '0;
        else if (!sw_stby) adr_d = addr_in;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) adr_q <= '0;
        else        adr_q <= adr_d;
    end

    assign gpio_mode = (mode == MODE_MIXED) || (mode == MODE_SINGLE);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        pin_role_e role;
        logic      drv_en, drv_val;

        always_comb begin
            unique case (mode)
                MODE_SINGLE:            role = regs.dir[i] ? ROLE_GPO : ROLE_IN;
                MODE_MIXED:             role = regs.dir[i] ? ROLE_ADR : ROLE_IN;
                MODE_EXP_A, MODE_EXP_B: role = ROLE_ADR;
                default:                role = ROLE_IN;
            endcase
        end

        always_comb begin
            drv_en  = 1'b0;
            drv_val = 1'b0;
            unique case (role)
                ROLE_GPO: begin
                    drv_en  = 1'b1;
                    drv_val = regs.dat[i];
                end
                ROLE_ADR: begin
                    drv_en  = !(sw_stby && !stby_oe);
                    drv_val = adr_q[i];
                end
                default: begin
                    drv_en  = 1'b0;
                    drv_val = 1'b0;
                end
            endcase
            if (hw_stby) drv_en = 1'b0;
        end

        assign pin_oe[i]   = drv_en;
        assign pin_out[i]  = drv_en & drv_val;
        assign pin_pu[i]   = regs.pul[i] && (role == ROLE_IN) && gpio_mode && !hw_stby;
        assign gpo_mask[i] = (role == ROLE_GPO);
    end

    // R9
    pu_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        (pin_pu & pin_oe) == '0);

    // R6
    bus_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((mode == MODE_EXP_A || mode == MODE_EXP_B) && !sw_stby && !hw_stby)
        |-> (pin_oe == {PORT_W{1'b1}}));

    // R12
    adr_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sw_stby && !hw_stby) |=> $stable(adr_q));

    // R10
    hw_float_chk: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |-> (pin_oe == '0 && pin_pu == '0));
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              man_rst,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              stby_oe,
    input  logic [MODE_W-1:0] mode,
    input  logic [BUS_AW-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] addr_in,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pu
);
    port_regs_t        regs;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] gpo_mask;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    gpio_regs u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .hw_stby  (hw_stby),
        .man_rst  (man_rst),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .pin_sync (pin_sync),
        .gpo_mask (gpo_mask),
        .regs     (regs),
        .rdata    (rdata)
    );

    gpio_pinmux u_mux (
        .clk      (clk),
        .por_n    (por_n),
        .hw_stby  (hw_stby),
        .sw_stby  (sw_stby),
        .stby_oe  (stby_oe),
        .mode     (mode),
        .regs     (regs),
        .addr_in  (addr_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .pin_pu   (pin_pu),
        .gpo_mask (gpo_mask)
    );
endmodule

// File: tb/gpio_port_ctl_tb_top.sv
module gpio_port_ctl_tb_top;
    localparam logic [15:0] A_DIR = 16'hFEBA;
    localparam logic [15:0] A_DAT = 16'hFF6A;
    localparam logic [15:0] A_PIN = 16'hFF5A;
    localparam logic [15:0] A_PUL = 16'hFF71;

    logic clk = 1'b0;
    logic por_n, man_rst, hw_stby, sw_stby, stby_oe, wr_en, rd_en;
    logic [2:0]  mode;
    logic [15:0] addr;
    logic [7:0]  wdata, rdata, addr_in, pin_in, pin_out, pin_oe, pin_pu;
    int nvec = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    gpio_port_ctl dut_i (
        .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .stby_oe(stby_oe), .mode(mode), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .addr_in(addr_in), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        por_n = 1'b0; man_rst = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0; stby_oe = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; mode = 3'd7; addr = 16'h0000; wdata = 8'h00;
        addr_in = 8'h00; pin_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1;

        // R1 reset state
        bus_rd(A_DAT, rd); chk("R1 data reset", rd, 8'h00);
        bus_rd(A_PUL, rd); chk("R1 pull reset", rd, 8'h00);
        chk("R1 oe reset", pin_oe, 8'h00);
        chk("R1 pu reset", pin_pu, 8'h00);

        // R2 write/read timing and strobe gating
        addr = A_DAT; wdata = 8'hA5; wr_en = 1'b1; rd_en = 1'b1;
        #1 chk("R2 old value before edge", rdata, 8'h00);
        tick(); wr_en = 1'b0; rd_en = 1'b0;
        bus_rd(A_DAT, rd); chk("R2 data readback", rd, 8'hA5);
        addr = A_DAT; #1 chk("R2 rd_en low", rdata, 8'h00);
        bus_wr(A_PUL, 8'h3C);
        bus_rd(A_PUL, rd); chk("R2 pull readback", rd, 8'h3C);

        // R3 writes to read-only and unmapped addresses
        bus_wr(A_PIN, 8'hFF);
        bus_wr(16'h1234, 8'hFF);
        bus_wr(16'hFF6B, 8'hFF);
        bus_rd(A_DAT, rd); chk("R3 data untouched", rd, 8'hA5);
        bus_rd(A_PUL, rd); chk("R3 pull untouched", rd, 8'h3C);
        chk("R3 dir untouched", pin_oe, 8'h00);
        bus_wr(A_PUL, 8'h00);

        // R4 mode 7 sweep
        mode = 3'd7;
        for (int d = 0; d < 256; d += 5) begin
            logic [7:0] dv, dr;
            dv = 8'(d); dr = dv ^ 8'h3C;
            bus_wr(A_DIR, dv);
            bus_wr(A_DAT, dr);
            chk("R4 oe", pin_oe, dv);
            chk("R4 out", pin_out, dv & dr);
        end

        // R8 pin-state sweep
        bus_wr(A_DIR, 8'hF0);
        bus_wr(A_DAT, 8'h5A);
        for (int p = 0; p < 256; p++) begin
            pin_in = 8'(p);
            tick(); tick();
            bus_rd(A_PIN, rd);
            chk("R8 pin state", rd, (8'hF0 & 8'h5A) | (8'h0F & 8'(p)));
        end
        pin_in = 8'hC3;
        tick();
        bus_rd(A_PIN, rd);
        chk("R8 one edge only", rd, 8'h50 | (8'h0F & 8'hFF));

        // R9 pull-up rule
        bus_wr(A_DIR, 8'h0F);
        bus_wr(A_PUL, 8'hFF);
        mode = 3'd7; #1 chk("R9 mode7", pin_pu, 8'hF0);
        mode = 3'd6; #1 chk("R9 mode6", pin_pu, 8'hF0);
        mode = 3'd5; #1 chk("R9 mode5", pin_pu, 8'h00);
        mode = 3'd2; #1 chk("R9 mode2", pin_pu, 8'h00);
        bus_wr(A_PUL, 8'h00);

        // R7 non-port modes
        for (int m = 0; m < 4; m++) begin
            mode = 3'(m);
            #1 chk("R7 oe", pin_oe, 8'h00);
        end

        // R5 mode 6 address sweep
        mode = 3'd6;
        bus_wr(A_DIR, 8'h33);
        for (int a = 0; a < 256; a += 3) begin
            addr_in = 8'(a);
            tick();
            chk("R5 oe", pin_oe, 8'h33);
            chk("R5 out", pin_out, 8'(a) & 8'h33);
        end

        // R6 modes 4 and 5
        for (int m = 4; m < 6; m++) begin
            mode = 3'(m);
            for (int a = 1; a < 256; a += 7) begin
                addr_in = 8'(a);
                tick();
                chk("R6 oe", pin_oe, 8'hFF);
                chk("R6 out", pin_out, 8'(a));
            end
        end

        // R12 software standby hold
        mode = 3'd4; addr_in = 8'h6C; tick();
        sw_stby = 1'b1; stby_oe = 1'b1; addr_in = 8'h93;
        tick(); tick();
        chk("R12 held addr", pin_out, 8'h6C);
        chk("R12 oe kept", pin_oe, 8'hFF);

        // R13 software standby float
        stby_oe = 1'b0;
        #1 chk("R13 addr oe off", pin_oe, 8'h00);
        chk("R13 addr out 0", pin_out, 8'h00);
        mode = 3'd7;
        sw_stby = 1'b0; bus_wr(A_DIR, 8'hF0); bus_wr(A_DAT, 8'hAA);
        sw_stby = 1'b1; tick();
        chk("R13 gpo oe", pin_oe, 8'hF0);
        chk("R13 gpo out", pin_out, 8'hA0);
        sw_stby = 1'b0; tick();
        bus_rd(A_DAT, rd); chk("R13 data kept", rd, 8'hAA);

        // R11 manual reset
        man_rst = 1'b1;
        bus_wr(A_DAT, 8'h11);
        man_rst = 1'b0;
        bus_rd(A_DAT, rd); chk("R11 write dropped", rd, 8'hAA);
        chk("R11 dir kept", pin_oe, 8'hF0);

        // R10 hardware standby
        bus_wr(A_DIR, 8'hFF);
        bus_wr(A_DAT, 8'h77);
        bus_wr(A_PUL, 8'hFF);
        hw_stby = 1'b1;
        #1 chk("R10 oe off", pin_oe, 8'h00);
        chk("R10 pu off", pin_pu, 8'h00);
        bus_wr(A_DAT, 8'h99);
        hw_stby = 1'b0;
        bus_rd(A_DAT, rd); chk("R10 data cleared", rd, 8'h00);
        bus_rd(A_PUL, rd); chk("R10 pull cleared", rd, 8'h00);
        chk("R10 dir cleared", pin_oe, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule